// File: doc/BRIEF.md
# Four-Channel Peripheral-to-Memory DMA Engine

This block moves data from up to four peripherals into memory. Software programs it through a small write-only 8-bit I/O port bus. Each channel has a 16-bit offset and a 16-bit count, and both are written one byte at a time through a single 8-bit port. A single pointer bit, shared by all channels, selects the low or the high byte, and a dedicated port clears that pointer. Each channel also has an 8-bit page register that supplies the upper memory address bits. Per-channel mask bits and a per-channel mode byte decide whether a channel may run.

When a peripheral raises its request line and its channel is eligible, the engine performs one memory write of the peripheral's data byte at `{page, offset}`. In the following cycle it acknowledges the peripheral. It then advances the offset, wrapping inside the 64 KB page, and decrements the count. Programming a count of N-1 gives N transfers. On the transfer made with count zero, the engine pulses terminal count, masks the channel so it stops, and leaves the count at 0xFFFF.

Top module: `dma4_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all four channels are masked, the mode of every channel is not a runnable mode, and the byte pointer selects the low byte. `dack`, `mem_we`, `tc`, `mem_addr` and `mem_wdata` are all zero. Requests made before any programming are not serviced.
- R2: A write to port 0x8 picks a channel with data bits [1:0]. Data bit 2 = 1 masks that channel and data bit 2 = 0 unmasks it. A masked channel's requests are not serviced.
- R3: The byte pointer is shared by every offset and count port. It toggles after each write to any of those ports. A write of any value to port 0xA returns it to the low byte.
- R4: Port address {0, ch[1:0], 0} writes the offset of channel ch, and port address {0, ch[1:0], 1} writes its count. With the pointer at low, the write lands in bits [7:0]; with the pointer at high, it lands in bits [15:8].
- R5: A write to port 0x9 stores the mode for the channel in data bits [1:0]. A channel is eligible only when its stored bits [7:6] = 01 (single) and bits [3:2] = 01 (peripheral to memory). Any other mode makes its requests have no effect.
- R6: If an eligible, unmasked channel has `dreq` high in a cycle with no I/O write, then in the next cycle that channel's `dack` bit and `mem_we` are high for one cycle, `mem_wdata` equals the `dev_data` sampled with the request, and `mem_addr` = {page, offset} before the increment.
- R7: When several channels qualify, the lowest-numbered channel is served and the others wait. At most one `dack` bit is high.
- R8: After each transfer the channel's offset increments by one, wrapping from 0xFFFF to 0x0000. The page register is never changed by transfers.
- R9: A count programmed as N-1 gives exactly N transfers. The transfer made at count 0 raises `tc` together with `mem_we`, sets the channel's mask bit, and leaves the count at 0xFFFF. Later requests on that channel are ignored until it is unmasked.
- R10: Port address 0xC + ch writes the page register of channel ch.
- R11: In any cycle with `io_wr` high, no request is serviced, so the next cycle shows no `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O port write strobe |
| io_addr | input | 4 | I/O port address |
| io_wdata | input | 8 | I/O port write data |
| dreq | input | 4 | Per-channel peripheral transfer request |
| dev_data | input | 8 | Peripheral data byte to be stored |
| dack | output | 4 | Per-channel one-cycle acknowledge |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory byte address {page, offset} |
| mem_wdata | output | 8 | Memory write data |
| tc | output | 1 | Terminal-count pulse for the current transfer |

## Verification
The assertions check on every cycle that at most one acknowledge is active, and that a write strobe always comes with exactly one acknowledge that follows a request. They also check that terminal count appears only inside a transfer and masks its channel, that offsets step by one while pages stay put, and that an I/O write cycle suppresses service. Only the bench scenarios can show the programming paths: the shared byte pointer landing bytes in the wrong register when no clear is written, the transfer count matching the programmed value plus one, wrapping inside the page, mode filtering, and the choice among competing requests. These outcomes depend on the sequence of port writes rather than on any single cycle.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int OFS_W  = 16;
    localparam int PAGE_W = 8;
    localparam int DATA_W = 8;
    localparam int IO_AW  = 4;
    localparam int MEM_AW = PAGE_W + OFS_W;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        XM_DEMAND  = 2'b00,
        XM_SINGLE  = 2'b01,
        XM_BLOCK   = 2'b10,
        XM_CASCADE = 2'b11
    } xmode_e;

    typedef enum logic [1:0] {
        DIR_CHECK   = 2'b00,
        DIR_TO_MEM  = 2'b01,
        DIR_FROM_MEM= 2'b10,
        DIR_BAD     = 2'b11
    } xdir_e;

    typedef struct packed {
        xmode_e kind;
        xdir_e  dir;
    } chan_mode_t;

    typedef enum logic [2:0] {
        P_NONE,
        P_OFS,
        P_CNT,
        P_MASK,
        P_MODE,
        P_PTRCLR,
        P_PAGE
    } port_e;

    typedef struct packed {
        port_e           kind;
        logic [CH_W-1:0] ch;
    } port_sel_t;

    typedef struct packed {
        logic              valid;
        logic [CH_W-1:0]   ch;
        logic [MEM_AW-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              last;
    } xfer_t;

    function automatic port_sel_t decode_port(input logic [IO_AW-1:0] a);
        port_sel_t p;
        p.ch   = a[2:1];
        p.kind = P_NONE;
        if (!a[3]) begin
            p.kind = a[0] ? P_CNT : P_OFS;
        end else begin
            case (a[2:0])
                3'd0: p.kind = P_MASK;
                3'd1: p.kind = P_MODE;
                3'd2: p.kind = P_PTRCLR;
                3'd4, 3'd5, 3'd6, 3'd7: begin
                    p.kind = P_PAGE;
                    p.ch   = a[1:0];
                end
                default: p.kind = P_NONE;
            endcase
        end
        return p;
    endfunction

    function automatic logic mode_runs(input chan_mode_t m);
        return (m.kind == XM_SINGLE) && (m.dir == DIR_TO_MEM);
    endfunction

endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
    import dma4_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_wr,
    input  logic [IO_AW-1:0]     io_addr,
    input  logic [BYTE_W-1:0]    io_wdata,
    input  logic                 svc_valid,
    input  logic [CH_W-1:0]      svc_ch,
    output logic [NCH-1:0]       elig,
    output logic [MEM_AW-1:0]    sel_addr,
    output logic                 sel_last
);

    logic [NCH-1:0]             mask_q;
    chan_mode_t                 mode_q [NCH];
    logic                       ptr_hi_q;
    logic [NCH-1:0][OFS_W-1:0]  ofs_q;
    logic [NCH-1:0][OFS_W-1:0]  cnt_q;
    logic [NCH-1:0][PAGE_W-1:0] page_q;
    port_sel_t                  sel;
    logic [CH_W-1:0]            dch;

    always_comb begin
        sel = decode_port(io_addr);
        dch = io_wdata[CH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '1;
            ptr_hi_q <= 1'b0;
            ofs_q    <= '0;
            cnt_q    <= '0;
            page_q   <= '0;
            for (int i = 0; i < NCH; i++) mode_q[i] <= '{kind: XM_DEMAND, dir: DIR_CHECK};
        end else begin
            if (io_wr) begin
                case (sel.kind)
                    P_OFS: begin
                        if (ptr_hi_q) ofs_q[sel.ch][OFS_W-1:BYTE_W] <= io_wdata;
                        else          ofs_q[sel.ch][BYTE_W-1:0]     <= io_wdata;
                        ptr_hi_q <= ~ptr_hi_q;
                    end
                    P_CNT: begin
                        if (ptr_hi_q) cnt_q[sel.ch][OFS_W-1:BYTE_W] <= io_wdata;
                        else          cnt_q[sel.ch][BYTE_W-1:0]     <= io_wdata;
                        ptr_hi_q <= ~ptr_hi_q;
                    end
                    P_MASK:   mask_q[dch] <= io_wdata[2];
                    P_MODE:   mode_q[dch] <= '{kind: xmode_e'(io_wdata[7:6]),
                                               dir:  xdir_e'(io_wdata[3:2])};
                    P_PTRCLR: ptr_hi_q <= 1'b0;
                    P_PAGE:   page_q[sel.ch] <= io_wdata;
                    default: ;
                endcase
            end
            if (svc_valid) begin
                ofs_q[svc_ch] <= ofs_q[svc_ch] + 1'b1;
                cnt_q[svc_ch] <= cnt_q[svc_ch] - 1'b1;
                if (cnt_q[svc_ch] == '0) mask_q[svc_ch] <= 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_elig
            assign elig[g] = !mask_q[g] && mode_runs(mode_q[g]);

            AST_TC_MASKS: assert property (@(posedge clk) disable iff (rst)
                (svc_valid && svc_ch == g && cnt_q[g] == '0) |=> mask_q[g]) // R9
                else $error("terminal count left channel unmasked");

            AST_OFS_STEP: assert property (@(posedge clk) disable iff (rst)
                (svc_valid && svc_ch == g) |=> (ofs_q[g] == $past(ofs_q[g]) + 1'b1)) // R8
                else $error("offset did not advance by one");
        end
    endgenerate

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        svc_valid |=> $stable(page_q)) // R8
        else $error("page changed by a transfer");

    assign sel_addr = {page_q[svc_ch], ofs_q[svc_ch]};
    assign sel_last = (cnt_q[svc_ch] == '0);

endmodule

// File: rtl/dma4_arb.sv
module dma4_arb
    import dma4_pkg::*;
(
    input  logic [NCH-1:0]  req,
    input  logic [NCH-1:0]  elig,
    input  logic            hold,
    output logic            grant_valid,
    output logic [CH_W-1:0] grant_ch
);

    logic [NCH-1:0] cand;

    always_comb begin
        cand     = req & elig;
        grant_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) grant_ch = CH_W'(i);
        end
        grant_valid = (|cand) && !hold;
    end

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                io_wr,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic [BYTE_W-1:0]   io_wdata,
    input  logic [NCH-1:0]      dreq,
    input  logic [DATA_W-1:0]   dev_data,
    output logic [NCH-1:0]      dack,
    output logic                mem_we,
    output logic [MEM_AW-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                tc
);

    logic [NCH-1:0]    elig;
    logic              grant_valid;
    logic [CH_W-1:0]   grant_ch;
    logic [MEM_AW-1:0] sel_addr;
    logic              sel_last;
    xfer_t             next_x;
    xfer_t             cur_x;

    dma4_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .io_wr     (io_wr),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .svc_valid (grant_valid),
        .svc_ch    (grant_ch),
        .elig      (elig),
        .sel_addr  (sel_addr),
        .sel_last  (sel_last)
    );

    dma4_arb u_arb (
        .req         (dreq),
        .elig        (elig),
        .hold        (io_wr),
        .grant_valid (grant_valid),
        .grant_ch    (grant_ch)
    );

    always_comb begin
        next_x = '0;
        if (grant_valid) begin
            next_x.valid = 1'b1;
            next_x.ch    = grant_ch;
            next_x.addr  = sel_addr;
            next_x.data  = dev_data;
            next_x.last  = sel_last;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_x <= '0;
        else     cur_x <= next_x;
    end

    always_comb begin
        dack = '0;
        if (cur_x.valid) dack[cur_x.ch] = 1'b1;
        mem_we    = cur_x.valid;
        mem_addr  = cur_x.addr;
        mem_wdata = cur_x.data;
        tc        = cur_x.last;
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack)) // R7
        else $error("more than one acknowledge");

    AST_WE_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($countones(dack) == 1)) // R6
        else $error("write strobe without a single acknowledge");

    AST_TC_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        tc |-> mem_we) // R9
        else $error("terminal count outside a transfer");

    AST_IO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        io_wr |=> !mem_we) // R11
        else $error("transfer granted during an I/O write");

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ackreq
            AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
                dack[g] |-> $past(dreq[g])) // R6
                else $error("acknowledge without a request");
        end
    endgenerate

endmodule

// File: tb/dma4_engine_test.sv
`timescale 1ns/1ps
module dma4_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [3:0]  dreq = '0;
    logic [7:0]  dev_data = '0;
    logic [3:0]  dack;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        tc;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma4_engine uut (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .dreq(dreq), .dev_data(dev_data), .dack(dack), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tc(tc)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [3:0]  m_mask;
    logic [7:0]  m_mode [4];
    logic        m_hi;
    logic [15:0] m_ofs [4];
    logic [15:0] m_cnt [4];
    logic [7:0]  m_page [4];
    logic [3:0]  e_ack;
    logic        e_we, e_tc;
    logic [23:0] e_addr;
    logic [7:0]  e_data;

    always @(posedge clk) begin
        e_ack = '0; e_we = 1'b0; e_tc = 1'b0; e_addr = '0; e_data = '0;
        if (rst) begin
            m_mask = 4'hF; m_hi = 1'b0;
            for (int i = 0; i < 4; i++) begin
                m_mode[i] = 8'h00; m_ofs[i] = 16'h0; m_cnt[i] = 16'h0; m_page[i] = 8'h0;
            end
        end else if (io_wr) begin
            int a;
            a = io_addr;
            if (a < 8) begin
                int c;
                c = a / 2;
                if (a % 2 == 0) begin
                    if (m_hi) m_ofs[c][15:8] = io_wdata; else m_ofs[c][7:0] = io_wdata;
                end else begin
                    if (m_hi) m_cnt[c][15:8] = io_wdata; else m_cnt[c][7:0] = io_wdata;
                end
                m_hi = !m_hi;
            end else if (a == 8) m_mask[io_wdata[1:0]] = io_wdata[2];
            else if (a == 9) m_mode[io_wdata[1:0]] = io_wdata;
            else if (a == 10) m_hi = 1'b0;
            else if (a >= 12) m_page[a - 12] = io_wdata;
        end else begin
            int pick;
            pick = -1;
            for (int i = 3; i >= 0; i--) begin
                if (dreq[i] && !m_mask[i] && m_mode[i][7:6] == 2'b01 && m_mode[i][3:2] == 2'b01)
                    pick = i;
            end
            if (pick >= 0) begin
                e_ack[pick] = 1'b1;
                e_we   = 1'b1;
                e_addr = {m_page[pick], m_ofs[pick]};
                e_data = dev_data;
                e_tc   = (m_cnt[pick] == 16'h0);
                m_ofs[pick] = m_ofs[pick] + 16'h1;
                m_cnt[pick] = m_cnt[pick] - 16'h1;
                if (e_tc) m_mask[pick] = 1'b1;
            end
        end
        #1;
        chk(dack == e_ack, "R7 model dack", dack, e_ack);
        chk(mem_we == e_we, "R6 model mem_we", mem_we, e_we);
        chk(mem_addr == e_addr, "R8 model mem_addr", mem_addr, e_addr);
        chk(mem_wdata == e_data, "R6 model mem_wdata", mem_wdata, e_data);
        chk(tc == e_tc, "R9 model tc", tc, e_tc);
    end

    task automatic io_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic pulse_req(input logic [3:0] r, input logic [7:0] d, input string tag,
                             input logic [3:0] x_ack, input logic [23:0] x_addr, input logic x_tc);
        @(negedge clk);
        dreq = r; dev_data = d;
        @(posedge clk);
        dreq = r;
        @(negedge clk);
        dreq = '0;
        chk(dack == x_ack, tag, dack, x_ack);
        if (x_ack != 0) begin
            chk(mem_addr == x_addr, tag, mem_addr, x_addr);
            chk(mem_wdata == d, tag, mem_wdata, d);
            chk(tc == x_tc, tag, tc, x_tc);
        end else begin
            chk(mem_we == 1'b0, tag, mem_we, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset, nothing runs before programming
        chk(dack == 0 && !mem_we && !tc && mem_addr == 0 && mem_wdata == 0, "R1 reset idle", {dack, mem_we, tc}, 0);
        pulse_req(4'hF, 8'h11, "R1 unprogrammed request", 4'h0, 24'h0, 1'b0);

        // channel 2: page 0x12, offset 0xFFFE, count 2 -> three transfers (R4, R10)
        io_write(4'h8, 8'h06);
        io_write(4'h9, 8'h46);
        io_write(4'hA, 8'h00);
        io_write(4'h4, 8'hFE);
        io_write(4'h4, 8'hFF);
        io_write(4'hE, 8'h12);
        io_write(4'hA, 8'h00);
        io_write(4'h5, 8'h02);
        io_write(4'h5, 8'h00);
        pulse_req(4'h4, 8'hA1, "R2 masked channel", 4'h0, 24'h0, 1'b0);
        io_write(4'h8, 8'h02);
        pulse_req(4'h4, 8'hA1, "R6 R4 R10 first transfer", 4'h4, 24'h12FFFE, 1'b0);
        pulse_req(4'h4, 8'hB2, "R8 second transfer", 4'h4, 24'h12FFFF, 1'b0);
        pulse_req(4'h4, 8'hC3, "R8 R9 wrap and terminal count", 4'h4, 24'h120000, 1'b1);
        pulse_req(4'h4, 8'hD4, "R9 stopped after terminal count", 4'h0, 24'h0, 1'b0);

        // R3: shared pointer without a clear between ports
        io_write(4'h9, 8'h45);
        io_write(4'hA, 8'h00);
        io_write(4'h2, 8'h34);
        io_write(4'h3, 8'h00);
        io_write(4'h2, 8'h56);
        io_write(4'h8, 8'h01);
        pulse_req(4'h2, 8'h5A, "R3 shared byte pointer", 4'h2, 24'h000056, 1'b1);

        // R7: channels 0 and 3 competing
        io_write(4'h9, 8'h44);
        io_write(4'h9, 8'h47);
        io_write(4'hA, 8'h00);
        io_write(4'h0, 8'h00);
        io_write(4'h0, 8'h20);
        io_write(4'h1, 8'h05);
        io_write(4'h1, 8'h00);
        io_write(4'h6, 8'h00);
        io_write(4'h6, 8'h10);
        io_write(4'h7, 8'h05);
        io_write(4'h7, 8'h00);
        io_write(4'hF, 8'h03);
        io_write(4'h8, 8'h00);
        io_write(4'h8, 8'h03);
        pulse_req(4'h9, 8'h77, "R7 lowest channel wins", 4'h1, 24'h002000, 1'b0);
        pulse_req(4'h8, 8'h78, "R7 waiting channel served", 4'h8, 24'h031000, 1'b0);

        // R11: I/O write cycle blocks service
        @(negedge clk);
        io_wr = 1'b1; io_addr = 4'hB; io_wdata = 8'hFF; dreq = 4'h1;
        @(negedge clk);
        io_wr = 1'b0; dreq = 4'h0;
        chk(mem_we == 1'b0, "R11 no transfer during I/O write", mem_we, 0);
        pulse_req(4'h1, 8'h99, "R11 served after write", 4'h1, 24'h002001, 1'b0);

        // R5: non-single mode ignored
        io_write(4'h9, 8'h84);
        pulse_req(4'h1, 8'h9A, "R5 block mode ignored", 4'h0, 24'h0, 1'b0);
        io_write(4'h9, 8'h48);
        pulse_req(4'h1, 8'h9B, "R5 read direction ignored", 4'h0, 24'h0, 1'b0);
        io_write(4'h9, 8'h44);
        io_write(4'h8, 8'h04);
        pulse_req(4'h1, 8'h9C, "R2 mask re-applied", 4'h0, 24'h0, 1'b0);
        io_write(4'h8, 8'h00);
        pulse_req(4'h1, 8'h9D, "R2 R5 unmasked again", 4'h1, 24'h002002, 1'b0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule